// File: doc/BRIEF.md
# Strap-sampling status LED multiplexer

This block sits between a 10/100 Ethernet PHY core and a small group of pins that do two jobs. While the active-low reset is held, the duplex and speed indicator pins are treated as inputs. Their levels are sampled as capability straps, and the five PHY address pins are registered alongside them. Once reset is released, the same two pins are driven as status outputs. The other indicator pins then show link, activity, collision and the management interrupt.

A single configuration input chooses between two pin layouts. When it is high, the interrupt goes to the collision pin and activity has a pin of its own. When it is low, the interrupt goes to the activity pin and collisions get their own indication. In that layout activity is merged onto the link pin: the link pin is lit steadily while link is up and blinks at a fixed rate while stretched activity is present. Short activity and collision events are stretched to a minimum visible time so that a one-cycle event still gives a blink a person can see.

Top module: `strap_led_mux`

## Requirements
- R1: At each rising clock edge where `rst_n` is sampled low, `strap_adv_fd` takes the level of `dup_pin_in`. A high level means full-duplex capability is advertised (1).
- R2: At each rising clock edge where `rst_n` is sampled low, `strap_adv_100` takes the inverse of `spd_pin_in`. A low pin level means 100 Mb/s capability is advertised (`strap_adv_100` = 1).
- R3: Both strap outputs and `phy_addr` hold their values at every edge where `rst_n` is sampled high. They are captured again during the next reset, so each reset can give different values.
- R4: `dup_pin_oe` and `spd_pin_oe` are 0 while reset is low. Both become 1 after the first rising edge at which `rst_n` is sampled high. Until that edge the link, activity and collision pins are driven 1, which is dark.
- R5: After reset, `dup_pin_out` is the inverse of `full_dup`, so it is active low. `spd_pin_out` equals `speed_100`: 1 for 100 Mb/s and 0 for 10 Mb/s.
- R6: `phy_addr` is a register that takes `addr_pins` at each edge where `rst_n` is sampled low.
- R7: An activity or collision event sampled high at an edge makes its stretched indication active from that edge for exactly `STRETCH_CYC` cycles. A new event during the window restarts the full window.
- R8: With `irq_cfg` = 1, the pin outputs are driven as follows, all active low:
  - `col_pin_out` shows the inverse of `mgmt_irq`, and collision events have no effect on it.
  - `act_pin_out` shows stretched activity.
  - `link_pin_out` shows `link_up` steadily.
- R9: With `irq_cfg` = 0, `act_pin_out` shows the inverse of `mgmt_irq`. `col_pin_out` shows stretched collision, active low.
- R10: With `irq_cfg` = 0, `link_pin_out` is 1 while link is down. It is 0 while link is up and there is no stretched activity. While stretched activity is present, it is lit for `BLINK_CYC` cycles, then dark for `BLINK_CYC` cycles, and repeats, starting lit at the edge where the stretch begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset; the strap sampling window |
| irq_cfg | input | 1 | Pin layout select: 1 puts the interrupt on the collision pin, 0 puts it on the activity pin |
| addr_pins | input | ADDR_W | PHY address pins |
| dup_pin_in | input | 1 | Level read from the duplex pin |
| spd_pin_in | input | 1 | Level read from the speed pin |
| link_up | input | 1 | Link status from the core |
| speed_100 | input | 1 | 1 when the core runs at 100 Mb/s |
| full_dup | input | 1 | 1 when the core runs full duplex |
| act_evt | input | 1 | Receive/transmit activity event |
| col_evt | input | 1 | Collision event |
| mgmt_irq | input | 1 | Management interrupt request, active high |
| dup_pin_out | output | 1 | Duplex pin drive value |
| dup_pin_oe | output | 1 | Duplex pin output enable |
| spd_pin_out | output | 1 | Speed pin drive value |
| spd_pin_oe | output | 1 | Speed pin output enable |
| link_pin_out | output | 1 | Link (or link/activity) pin, active low |
| act_pin_out | output | 1 | Activity or interrupt pin, active low |
| col_pin_out | output | 1 | Collision or interrupt pin, active low |
| strap_adv_fd | output | 1 | Latched full-duplex advertise strap |
| strap_adv_100 | output | 1 | Latched 100 Mb/s advertise strap |
| phy_addr | output | ADDR_W | Registered PHY address |

## Verification
The assertions assume the following about the inputs:
- All status and event inputs are synchronous to `clk`.
- `rst_n` is low from time zero, so the strap registers have been loaded before any hold property applies.
- The pin read-back inputs carry the strap levels only while reset is low.

The stimulus keeps within these limits by changing every input on the falling clock edge and by starting each run inside a reset. Stretch windows are left to expire between scenarios so that each pulse-width measurement begins from idle.

// File: rtl/strap_led_pkg.sv
package strap_led_pkg;
  localparam int unsigned NUM_EVT = 2;
  localparam int unsigned EVT_ACT = 0;
  localparam int unsigned EVT_COL = 1;

  typedef struct packed {
    logic adv_fd;
    logic adv_100;
  } strap_t;

  // indicator pins are active low: a lit lamp drives 0
  function automatic logic lamp(input logic on);
    return ~on;
  endfunction
endpackage

// File: rtl/strap_capture.sv
module strap_capture
  import strap_led_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dup_pin_in,
  input  logic              spd_pin_in,
  input  logic [ADDR_W-1:0] addr_pins,
  output strap_t            straps,
  output logic [ADDR_W-1:0] addr_q
);
  // sampling window is the reset period itself
  wire sample_en = !rst_n;

  always_ff @(posedge clk) begin
    if (sample_en) begin
      straps.adv_fd  <= dup_pin_in;
      straps.adv_100 <= ~spd_pin_in;
      addr_q         <= addr_pins;
    end
  end

  // R3: no strap movement while running
  p_strap_hold_r3: assert property (@(posedge clk)
    (rst_n && $past(rst_n)) |-> ($stable(straps) && $stable(addr_q)));
  // R1, R2: last sample before release is what is held
  p_strap_capture_r1: assert property (@(posedge clk)
    (rst_n && !$past(rst_n)) |-> (straps.adv_fd == $past(dup_pin_in)
                                  && straps.adv_100 == !$past(spd_pin_in)));
endmodule

// File: rtl/event_stretch.sv
module event_stretch #(
  parameter int unsigned HOLD_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  output logic stretched
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC);

  logic [CW-1:0] cnt;

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c, input logic e);
    if (e) return LOAD;
    if (c != '0) return c - 1'b1;
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= next_count(cnt, evt);
  end

  assign stretched = (cnt != '0);

  // R7: an event is visible from the next cycle on
  p_event_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> stretched);
  // R7: the window never closes right after a fresh event
  p_no_early_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stretched) |-> !$past(evt));
endmodule

// File: rtl/link_blinker.sv
module link_blinker #(
  parameter int unsigned HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic dark
);
  localparam int unsigned BW = $clog2(HALF_CYC + 1);
  localparam logic [BW-1:0] LAST = BW'(HALF_CYC - 1);

  logic [BW-1:0] cnt;
  wire wrap = active && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      cnt  <= '0;
      dark <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      dark <= ~dark;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end

  // R10: blinking only starts out of an active stretch
  p_blink_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dark) |-> $past(active));
endmodule

// File: rtl/strap_led_mux.sv
module strap_led_mux
  import strap_led_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned STRETCH_CYC = 1250000,
  parameter int unsigned BLINK_CYC   = 2500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_cfg,
  input  logic [ADDR_W-1:0] addr_pins,
  input  logic              dup_pin_in,
  input  logic              spd_pin_in,
  input  logic              link_up,
  input  logic              speed_100,
  input  logic              full_dup,
  input  logic              act_evt,
  input  logic              col_evt,
  input  logic              mgmt_irq,
  output logic              dup_pin_out,
  output logic              dup_pin_oe,
  output logic              spd_pin_out,
  output logic              spd_pin_oe,
  output logic              link_pin_out,
  output logic              act_pin_out,
  output logic              col_pin_out,
  output logic              strap_adv_fd,
  output logic              strap_adv_100,
  output logic [ADDR_W-1:0] phy_addr
);
  strap_t straps;
  logic   run_q;
  logic   blink_dark;
  logic [NUM_EVT-1:0] evt_raw;
  logic [NUM_EVT-1:0] evt_str;

  strap_capture #(.ADDR_W(ADDR_W)) u_straps (
    .clk(clk), .rst_n(rst_n), .dup_pin_in(dup_pin_in), .spd_pin_in(spd_pin_in),
    .addr_pins(addr_pins), .straps(straps), .addr_q(phy_addr)
  );
  assign strap_adv_fd  = straps.adv_fd;
  assign strap_adv_100 = straps.adv_100;

  // pins turn into outputs one edge after rst_n is seen high
  always_ff @(posedge clk) run_q <= rst_n;

  assign evt_raw[EVT_ACT] = act_evt;
  assign evt_raw[EVT_COL] = col_evt;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_stretch
    event_stretch #(.HOLD_CYC(STRETCH_CYC)) u_str (
      .clk(clk), .rst_n(rst_n), .evt(evt_raw[g]), .stretched(evt_str[g])
    );
  end

  link_blinker #(.HALF_CYC(BLINK_CYC)) u_blink (
    .clk(clk), .rst_n(rst_n), .active(evt_str[EVT_ACT]), .dark(blink_dark)
  );

  always_comb begin
    dup_pin_out  = 1'b1;
    spd_pin_out  = 1'b0;
    link_pin_out = 1'b1;
    act_pin_out  = 1'b1;
    col_pin_out  = 1'b1;
    if (run_q) begin
      dup_pin_out = lamp(full_dup);
      spd_pin_out = speed_100;
      if (irq_cfg) begin
        col_pin_out  = lamp(mgmt_irq);
        act_pin_out  = lamp(evt_str[EVT_ACT]);
        link_pin_out = lamp(link_up);
      end else begin
        act_pin_out  = lamp(mgmt_irq);
        col_pin_out  = lamp(evt_str[EVT_COL]);
        link_pin_out = lamp(link_up && !(evt_str[EVT_ACT] && blink_dark));
      end
    end
  end

  assign dup_pin_oe = run_q;
  assign spd_pin_oe = run_q;

  // R4: shared pins never drive while the straps are being read
  p_oe_off_r4: assert property (@(posedge clk)
    !rst_n |=> (!dup_pin_oe && !spd_pin_oe));
  p_oe_on_r4: assert property (@(posedge clk)
    rst_n |=> (dup_pin_oe && spd_pin_oe));
  // R8: collision activity cannot reach the pin carrying the interrupt
  p_col_suppressed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_cfg && !mgmt_irq) |-> col_pin_out);
  // R9: a stretched collision lights its pin in the split layout
  p_col_shown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !irq_cfg && evt_str[EVT_COL]) |-> !col_pin_out);
  // R10: link down keeps the link pin dark whatever the activity
  p_link_dark_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |-> link_pin_out);
endmodule

// File: tb/tb_strap_led_mux.sv
`timescale 1ns/1ps
module tb_strap_led_mux;
  localparam int STRETCH = 12;
  localparam int BLINK   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_cfg = 1'b1;
  logic [4:0] addr_pins = '0;
  logic dup_pin_in = 1'b0, spd_pin_in = 1'b1;
  logic link_up = 1'b0, speed_100 = 1'b0, full_dup = 1'b0;
  logic act_evt = 1'b0, col_evt = 1'b0, mgmt_irq = 1'b0;
  logic dup_pin_out, dup_pin_oe, spd_pin_out, spd_pin_oe;
  logic link_pin_out, act_pin_out, col_pin_out;
  logic strap_adv_fd, strap_adv_100;
  logic [4:0] phy_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  strap_led_mux #(.ADDR_W(5), .STRETCH_CYC(STRETCH), .BLINK_CYC(BLINK)) dut (
    .clk(clk), .rst_n(rst_n), .irq_cfg(irq_cfg), .addr_pins(addr_pins),
    .dup_pin_in(dup_pin_in), .spd_pin_in(spd_pin_in), .link_up(link_up),
    .speed_100(speed_100), .full_dup(full_dup), .act_evt(act_evt),
    .col_evt(col_evt), .mgmt_irq(mgmt_irq), .dup_pin_out(dup_pin_out),
    .dup_pin_oe(dup_pin_oe), .spd_pin_out(spd_pin_out), .spd_pin_oe(spd_pin_oe),
    .link_pin_out(link_pin_out), .act_pin_out(act_pin_out),
    .col_pin_out(col_pin_out), .strap_adv_fd(strap_adv_fd),
    .strap_adv_100(strap_adv_100), .phy_addr(phy_addr)
  );

  task automatic chk(input string req, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // hold reset with given pin levels, then release
  task automatic do_reset(input logic dup, input logic spd, input logic [4:0] a,
                          input int exp_fd, input int exp_100);
    @(negedge clk);
    rst_n = 1'b0; dup_pin_in = dup; spd_pin_in = spd; addr_pins = a;
    idle(3);
    chk("R4 oe off in reset", {30'd0, dup_pin_oe, spd_pin_oe}, 0);
    chk("R4 lamps dark in reset", {29'd0, link_pin_out, act_pin_out, col_pin_out}, 7);
    rst_n = 1'b1;
    dup_pin_in = ~dup; spd_pin_in = ~spd; addr_pins = ~a;
    @(negedge clk);
    chk("R4 oe on after release", {30'd0, dup_pin_oe, spd_pin_oe}, 3);
    chk("R1 duplex strap", int'(strap_adv_fd), exp_fd);
    chk("R2 speed strap", int'(strap_adv_100), exp_100);
    chk("R6 address", int'(phy_addr), int'(a));
    idle(5);
    chk("R3 straps held", {30'd0, strap_adv_fd, strap_adv_100}, exp_fd * 2 + exp_100);
    chk("R3 address held", int'(phy_addr), int'(a));
  endtask

  task automatic t_status();
    @(negedge clk);
    full_dup = 1'b1; speed_100 = 1'b1; #1;
    chk("R5 duplex lit", int'(dup_pin_out), 0);
    chk("R5 speed 100", int'(spd_pin_out), 1);
    full_dup = 1'b0; speed_100 = 1'b0; #1;
    chk("R5 duplex dark", int'(dup_pin_out), 1);
    chk("R5 speed 10", int'(spd_pin_out), 0);
  endtask

  // count low samples on a pin after pulses at loop steps 0 and (optional) second
  task automatic pulse_width(input bit on_col, input int second, input bit watch_col,
                             output int lows);
    lows = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if ((watch_col ? col_pin_out : act_pin_out) == 1'b0) lows++;
      if (on_col) col_evt = (i == 0 || i == second);
      else        act_evt = (i == 0 || i == second);
    end
    col_evt = 1'b0; act_evt = 1'b0;
  endtask

  task automatic t_cfg_high();
    int n;
    @(negedge clk);
    irq_cfg = 1'b1; link_up = 1'b1; mgmt_irq = 1'b1; #1;
    chk("R8 link steady", int'(link_pin_out), 0);
    chk("R8 irq on col pin", int'(col_pin_out), 0);
    chk("R8 act pin idle", int'(act_pin_out), 1);
    mgmt_irq = 1'b0;
    pulse_width(1'b1, -1, 1'b1, n);
    chk("R8 collision suppressed", n, 0);
    pulse_width(1'b0, -1, 1'b0, n);
    chk("R7 activity stretch", n, STRETCH);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (link_pin_out != 1'b0) n++;
      act_evt = (i == 0);
    end
    act_evt = 1'b0;
    chk("R8 link no blink", n, 0);
  endtask

  task automatic t_cfg_low();
    int n;
    int bad;
    @(negedge clk);
    irq_cfg = 1'b0; mgmt_irq = 1'b1; #1;
    chk("R9 irq on act pin", int'(act_pin_out), 0);
    chk("R9 col pin idle", int'(col_pin_out), 1);
    mgmt_irq = 1'b0;
    pulse_width(1'b1, -1, 1'b1, n);
    chk("R9 R7 collision stretch", n, STRETCH);
    pulse_width(1'b1, 5, 1'b1, n);
    chk("R7 retrigger", n, 5 + STRETCH);
    link_up = 1'b0;
    pulse_width(1'b0, -1, 1'b0, n);
    @(negedge clk);
    chk("R10 link down dark", int'(link_pin_out), 1);
    link_up = 1'b1;
    bad = 0;
    for (int i = 0; i < 24; i++) begin
      @(negedge clk);
      if (i >= 1) begin
        int exp_pin;
        exp_pin = (i <= STRETCH && (((i - 1) / BLINK) % 2) == 1) ? 1 : 0;
        if (int'(link_pin_out) != exp_pin) bad++;
      end
      act_evt = (i == 0);
    end
    act_evt = 1'b0;
    chk("R10 blink pattern mismatches", bad, 0);
    @(negedge clk);
    chk("R10 steady after stretch", int'(link_pin_out), 0);
  endtask

  initial begin
    idle(2);
    do_reset(1'b1, 1'b0, 5'h15, 1, 1);
    t_status();
    do_reset(1'b0, 1'b1, 5'h0a, 0, 0);
    do_reset(1'b1, 1'b1, 5'h1f, 1, 0);
    t_cfg_high();
    idle(STRETCH + 4);
    t_cfg_low();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule